// File: doc/BRIEF.md
# Q15 Fractional Multiplier with Optional Saturation

This block multiplies two signed 16-bit fixed-point fractions and returns a 32-bit signed fraction. Both operands are in Q15 form, which covers the range [-1.0, +1.0). The result is in Q31 form. The fractional product is the signed 32-bit integer product shifted left by one bit, so that its binary point lines up with Q31.

Only one operand pair cannot be represented: -1.0 times -1.0. Its true value, +1.0, lies outside Q31. A mode input picks what happens in that case. In wrap mode the raw bits are returned, which read as -1.0. In saturate mode the result is clamped to the largest positive Q31 value. The clamp logic works from the sign of the true product, so a negative out-of-range result would clamp to the most negative value. An overflow flag marks the case in either mode.

A one-cycle start strobe captures the operands and the mode bit. The result, the valid flag and the overflow flag are registered and appear on the next clock edge. When no start is given, the result register keeps its value.

Top module: `fmul_q15_sat`

## Requirements
- R1: Synchronous active-high reset clears the product output, the valid flag and the overflow flag to zero.
- R2: The valid flag is high in exactly the cycle after each cycle in which the start input is high, and low otherwise; back-to-back starts give back-to-back valid cycles.
- R3: For every operand pair other than 0x8000 × 0x8000, the product output equals the 32-bit two's-complement product of the two signed 16-bit operands shifted left by one bit (for example 0x7FFF × 0x7FFF gives 0x7FFE0002 and 0x8000 × 0x7FFF gives 0x80010000).
- R4: The overflow flag is high in the result cycle exactly when both captured operands were 0x8000, whatever the mode, and is low in every other cycle.
- R5: With the mode input at 0 (wrap), 0x8000 × 0x8000 yields 0x80000000.
- R6: With the mode input at 1 (saturate), 0x8000 × 0x8000 yields 0x7FFFFFFF.
- R7: The mode input has no effect on the product of any operand pair other than 0x8000 × 0x8000.
- R8: In a cycle after one where start is low, the product output keeps its previous value, and changes to the operand or mode inputs have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Capture operands and mode this cycle |
| sat_en_i | input | 1 | 1 = saturate the overflow case, 0 = wrap |
| op_a_i | input | 16 | Multiplicand, Q15 two's complement |
| op_b_i | input | 16 | Multiplier, Q15 two's complement |
| prod_o | output | 32 | Registered Q31 product |
| valid_o | output | 1 | Result valid, one cycle after start |
| ovf_o | output | 1 | -1.0 × -1.0 occurred in this result |

## Verification
Random operand pairs with a random mode bit test the shifted product over the whole input space and test that the mode has no effect away from the corner. The -1.0 × -1.0 pair is applied in both modes, which separates wrapping from clamping and checks that the flag does not depend on the mode. Near-corner pairs (0x8000 with 0x7FFF, 0x8000, 0x0001 and 0x0000, and 0x7FFF squared) catch a flag or clamp that triggers on one operand alone, and sign-handling errors. Streams of consecutive starts, and idle cycles with changing inputs, check the valid timing and that the result register holds its value.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  typedef enum logic {
    MODE_WRAP = 1'b0,
    MODE_SAT  = 1'b1
  } sat_mode_e;
endpackage

// File: rtl/fmul_core.sv
// Signed fractional product: integer product realigned to Q(2W-1).
module fmul_core #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] frac_o,   // product << 1, wrapped
  output logic           ovf_o,    // shifted result not representable
  output logic           neg_o     // sign of the true product
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] full;

  always_comb begin
    full   = $signed(a_i) * $signed(b_i);
    frac_o = {full[PW-2:0], 1'b0};
    // The shift loses information when the two top bits differ.
    ovf_o  = full[PW-1] ^ full[PW-2];
    neg_o  = full[PW-1];
  end
endmodule

// File: rtl/fmul_sat.sv
// Picks the wrapped value or the clamp bound for an out-of-range product.
module fmul_sat
  import fmul_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic [PW-1:0] frac_i,
  input  logic          ovf_i,
  input  logic          neg_i,
  input  sat_mode_e     mode_i,
  output logic [PW-1:0] res_o
);
  localparam logic [PW-1:0] MAXV = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] MINV = {1'b1, {(PW-1){1'b0}}};

  always_comb begin
    if (ovf_i && mode_i == MODE_SAT) res_o = neg_i ? MINV : MAXV;
    else                             res_o = frac_i;
  end
endmodule

// File: rtl/fmul_q15_sat.sv
module fmul_q15_sat
  import fmul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         sat_en_i,
  input  logic [15:0]  op_a_i,
  input  logic [15:0]  op_b_i,
  output logic [31:0]  prod_o,
  output logic         valid_o,
  output logic         ovf_o
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0]  NEG_ONE = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW-1:0] MAXV    = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] MINV    = {1'b1, {(PW-1){1'b0}}};

  logic [PW-1:0] frac, res;
  logic          ovf, neg;
  sat_mode_e     mode;

  assign mode = sat_mode_e'(sat_en_i);

  fmul_core #(.W(W)) u_core (
    .a_i(op_a_i), .b_i(op_b_i),
    .frac_o(frac), .ovf_o(ovf), .neg_o(neg)
  );

  fmul_sat #(.PW(PW)) u_sat (
    .frac_i(frac), .ovf_i(ovf), .neg_i(neg),
    .mode_i(mode), .res_o(res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_o  <= '0;
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= start_i;
      ovf_o   <= start_i & ovf;
      if (start_i) prod_o <= res;
    end
  end

  // R2: valid exactly one cycle after start
  p_valid_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> valid_o);
  p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !valid_o);
  // R4: flag only for the double negative-one pair
  p_ovf_only_corner_r4: assert property (@(posedge clk) disable iff (rst)
    (start_i && !(op_a_i == NEG_ONE && op_b_i == NEG_ONE)) |=> !ovf_o);
  p_ovf_on_corner_r4: assert property (@(posedge clk) disable iff (rst)
    (start_i && op_a_i == NEG_ONE && op_b_i == NEG_ONE) |=> ovf_o);
  // R5: wrap mode
  p_wrap_value_r5: assert property (@(posedge clk) disable iff (rst)
    (start_i && !sat_en_i && op_a_i == NEG_ONE && op_b_i == NEG_ONE)
      |=> prod_o == MINV);
  // R6: saturate mode
  p_sat_value_r6: assert property (@(posedge clk) disable iff (rst)
    (start_i && sat_en_i && op_a_i == NEG_ONE && op_b_i == NEG_ONE)
      |=> prod_o == MAXV);
  // R8: hold when idle
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(prod_o));
endmodule

// File: tb/sim_fmul_q15_sat.sv
module sim_fmul_q15_sat;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        sat_en_i = 1'b0;
  logic [15:0] op_a_i = '0;
  logic [15:0] op_b_i = '0;
  logic [31:0] prod_o;
  logic        valid_o, ovf_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fmul_q15_sat u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .sat_en_i(sat_en_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i),
    .prod_o(prod_o), .valid_o(valid_o), .ovf_o(ovf_o)
  );

  // Reference: exact fraction value scaled by 2^31, then wrap or clamp.
  function automatic logic [31:0] ref_prod(logic [15:0] a, logic [15:0] b, logic sat);
    longint p = longint'($signed(a)) * longint'($signed(b)) * 2;
    if (sat && p > 64'sd2147483647)  return 32'h7FFF_FFFF;
    if (sat && p < -64'sd2147483648) return 32'h8000_0000;
    return p[31:0];
  endfunction

  function automatic logic ref_ovf(logic [15:0] a, logic [15:0] b);
    return (a == 16'h8000) && (b == 16'h8000);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One operation: drive at negedge, check the result after the capture edge.
  task automatic do_op(logic [15:0] a, logic [15:0] b, logic sat, string req);
    @(negedge clk);
    op_a_i = a; op_b_i = b; sat_en_i = sat; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(req, "product", prod_o, ref_prod(a, b, sat));
    check("R2", "valid", 32'(valid_o), 32'd1);
    check("R4", "overflow", 32'(ovf_o), 32'(ref_ovf(a, b)));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "product after reset", prod_o, 32'h0);
    check("R1", "valid after reset", 32'(valid_o), 32'h0);
    check("R1", "overflow after reset", 32'(ovf_o), 32'h0);
    rst = 1'b0;

    // R5 / R6: the corner in both modes
    do_op(16'h8000, 16'h8000, 1'b0, "R5");
    check("R5", "wrap corner", prod_o, 32'h8000_0000);
    do_op(16'h8000, 16'h8000, 1'b1, "R6");
    check("R6", "sat corner", prod_o, 32'h7FFF_FFFF);

    // R3: directed near-corner values
    do_op(16'h7FFF, 16'h7FFF, 1'b1, "R3");
    check("R3", "max squared", prod_o, 32'h7FFE_0002);
    do_op(16'h8000, 16'h7FFF, 1'b1, "R3");
    check("R3", "neg one times max", prod_o, 32'h8001_0000);
    do_op(16'h8000, 16'h0001, 1'b1, "R3");
    do_op(16'h0001, 16'h8000, 1'b0, "R3");
    do_op(16'h8000, 16'h0000, 1'b1, "R3");
    do_op(16'hFFFF, 16'h8000, 1'b1, "R3");

    // R7: mode has no effect off the corner
    do_op(16'h8000, 16'h7FFF, 1'b0, "R7");
    check("R7", "wrap mode off corner", prod_o, 32'h8001_0000);

    // R8: hold while idle with changing inputs
    do_op(16'h4000, 16'h4000, 1'b0, "R3");
    held = prod_o;
    for (int i = 0; i < 4; i++) begin
      op_a_i = 16'h8000; op_b_i = 16'h8000; sat_en_i = i[0];
      @(negedge clk);
      check("R8", "held product", prod_o, held);
      check("R2", "no valid when idle", 32'(valid_o), 32'h0);
      check("R4", "no overflow when idle", 32'(ovf_o), 32'h0);
    end

    // R2: back-to-back starts
    begin
      logic [15:0] pa, pb; logic ps;
      @(negedge clk);
      pa = 16'($urandom); pb = 16'($urandom); ps = 1'($urandom);
      op_a_i = pa; op_b_i = pb; sat_en_i = ps; start_i = 1'b1;
      for (int k = 0; k < 20; k++) begin
        logic [15:0] na, nb; logic ns;
        na = (k == 10) ? 16'h8000 : 16'($urandom);
        nb = (k == 10) ? 16'h8000 : 16'($urandom);
        ns = 1'($urandom);
        @(negedge clk);
        check("R2", "stream product", prod_o, ref_prod(pa, pb, ps));
        check("R2", "stream valid", 32'(valid_o), 32'h1);
        check("R4", "stream overflow", 32'(ovf_o), 32'(ref_ovf(pa, pb)));
        pa = na; pb = nb; ps = ns;
        op_a_i = na; op_b_i = nb; sat_en_i = ns;
      end
      @(negedge clk);
      start_i = 1'b0;
      check("R2", "stream last", prod_o, ref_prod(pa, pb, ps));
    end

    // R3 / R7: random operands with random mode
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom); rb = 16'($urandom);
      if (i % 50 == 0) ra = 16'h8000;
      do_op(ra, rb, 1'($urandom), (i % 2) ? "R3" : "R7");
    end

    // R1: reset after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1", "product after second reset", prod_o, 32'h0);
    check("R1", "valid after second reset", 32'(valid_o), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule